// File: doc/BRIEF.md
# Three-Input Bitwise Ternary Logic Unit

This vector logic unit takes three operand words of equal width and an 8-bit truth table. It returns a word in which each bit is an arbitrary Boolean function of the three operand bits at the same position. An eight-bit table has enough entries to describe every one of the 256 functions of three inputs. A single operation can therefore stand in for chains of AND, OR, XOR and select steps, as found in hash rounds, carry-save adders and bit-sliced ciphers.

The table comes from one of two places. In immediate mode, one 8-bit selector applies to every bit position. In register-table mode, a table operand supplies a separate 8-bit table for each group of lanes, so the unit behaves as an array of independent three-input lookup tables. If the group size equals the full data width, one table serves the whole word.

Operands enter through a valid/ready handshake and pass through one registered stage. The result leaves through a second valid/ready handshake.

Top module: `tern_logic_unit`

## Requirements
- R1: For each bit position i, the index is {A0[i], A1[i], A2[i]}, with A0 as bit 2 (MSB) and A2 as bit 0. Output bit i equals bit `index` of the selected 8-bit table.
- R2: In immediate mode (opMode=0), each of the 256 selector values applies the function that the index rule gives to every bit position independently. This holds for all-zero, all-one and arbitrary operands.
- R3: Selector 0x80 in immediate mode gives A0 & A1 & A2.
- R4: Selector 0xFE in immediate mode gives A0 | A1 | A2.
- R5: Selector 0xCA in immediate mode gives a blend: A1 where A0 is 1, and A2 where A0 is 0.
- R6: In register-table mode (opMode=1), output bits [g*GROUP_W +: GROUP_W] use table tblSel[g*8 +: 8] and ignore immSel.
- R7: opMode, the tables and the operands are captured only on the cycle when inValid and inReady are both high. Changing them later has no effect on a held result.
- R8: An accepted input produces outValid=1 with its result on outData on the next clock edge.
- R9: While outValid=1 and outReady=0, outData and outValid hold steady and inReady=0. Otherwise inReady=1.
- R10: A synchronous active-high reset clears outValid to 0. outData is don't-care after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input transfer offered |
| inReady | output | 1 | Unit can take an input this cycle |
| opMode | input | 1 | 0: immediate selector, 1: per-group table operand |
| immSel | input | 8 | Immediate truth table |
| tblSel | input | 8*DATA_W/GROUP_W | One 8-bit table per lane group |
| srcA0 | input | DATA_W | Operand forming index bit 2 |
| srcA1 | input | DATA_W | Operand forming index bit 1 |
| srcA2 | input | DATA_W | Operand forming index bit 0 |
| outValid | output | 1 | Result register holds a result |
| outReady | input | 1 | Consumer takes the result |
| outData | output | DATA_W | Result word |

## Verification
Some faults would be visible at the ports one cycle after an accepted transfer: a wrong table bit, a swapped index order, or a mis-sliced group table. Each corrupts only the output bits whose operand pattern selects the bad entry. Sweeping every selector over several operand patterns makes sure every table entry is read at least once. A faulty full/empty state in the output register has a different signature. It shows up as lost or repeated results, or as inReady staying high under backpressure, and both appear in the first cycle that the consumer stalls. If capture is not gated by the handshake, the held output would change while the inputs change during that stall.

// File: rtl/tlu_pkg.sv
package tlu_pkg;
  typedef struct packed {
    logic capture;
  } ctrlStrobes_t;
endpackage

// File: rtl/tlu_ctrl.sv
module tlu_ctrl
  import tlu_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic         outReady,
  output logic         inReady,
  output logic         outValid,
  output ctrlStrobes_t strobes
);
  logic fullQ;

  assign inReady         = !fullQ || outReady;
  assign strobes.capture = inValid && inReady;
  assign outValid        = fullQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      fullQ <= 1'b0;
    end else if (strobes.capture) begin
      fullQ <= 1'b1;
    end else if (outReady) begin
      fullQ <= 1'b0;
    end
  end
endmodule

// File: rtl/tlu_datapath.sv
module tlu_datapath
  import tlu_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int GROUP_W = 8,
  localparam int NUM_GROUPS = DATA_W / GROUP_W,
  localparam int TBL_W = 8 * NUM_GROUPS
) (
  input  logic              clk,
  input  ctrlStrobes_t      strobes,
  input  logic              opMode,
  input  logic [7:0]        immSel,
  input  logic [TBL_W-1:0]  tblSel,
  input  logic [DATA_W-1:0] srcA0,
  input  logic [DATA_W-1:0] srcA1,
  input  logic [DATA_W-1:0] srcA2,
  output logic [DATA_W-1:0] outData
);
  logic [DATA_W-1:0] resultNext;
  logic [DATA_W-1:0] dataQ;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gen_group
    logic [7:0] groupTbl;
    assign groupTbl = opMode ? tblSel[g*8 +: 8] : immSel;
    for (genvar b = 0; b < GROUP_W; b++) begin : gen_lane
      localparam int Pos = g * GROUP_W + b;
      logic [2:0] laneIdx;
      assign laneIdx = {srcA0[Pos], srcA1[Pos], srcA2[Pos]};
      assign resultNext[Pos] = groupTbl[laneIdx];
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.capture) begin
      dataQ <= resultNext;
    end
  end

  assign outData = dataQ;
endmodule

// File: rtl/tern_logic_unit.sv
module tern_logic_unit
  import tlu_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int GROUP_W = 8,
  localparam int TBL_W = 8 * (DATA_W / GROUP_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic              opMode,
  input  logic [7:0]        immSel,
  input  logic [TBL_W-1:0]  tblSel,
  input  logic [DATA_W-1:0] srcA0,
  input  logic [DATA_W-1:0] srcA1,
  input  logic [DATA_W-1:0] srcA2,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData
);
  ctrlStrobes_t strobes;

  tlu_ctrl ctrl_i (
    .clk(clk), .rst(rst), .inValid(inValid), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .strobes(strobes)
  );

  tlu_datapath #(.DATA_W(DATA_W), .GROUP_W(GROUP_W)) dp_i (
    .clk(clk), .strobes(strobes), .opMode(opMode), .immSel(immSel),
    .tblSel(tblSel), .srcA0(srcA0), .srcA1(srcA1), .srcA2(srcA2),
    .outData(outData)
  );
endmodule

// File: rtl/tlu_checker.sv
module tlu_checker #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              inReady,
  input logic              opMode,
  input logic [7:0]        immSel,
  input logic [DATA_W-1:0] srcA0,
  input logic [DATA_W-1:0] srcA1,
  input logic [DATA_W-1:0] srcA2,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData
);
  logic takeImm;
  assign takeImm = inValid && inReady && !opMode;

  // R10
  a_r10_reset_clears: assert property (@(posedge clk) rst |=> !outValid);

  // R8
  a_r8_valid_next: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> outValid);

  // R9
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  a_r9_stall_ready: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |-> !inReady);

  a_r9_empty_ready: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> inReady);

  // R3
  a_r3_and: assert property (@(posedge clk) disable iff (rst)
    (takeImm && immSel == 8'h80) |=> outData == $past(srcA0 & srcA1 & srcA2));

  // R4
  a_r4_or: assert property (@(posedge clk) disable iff (rst)
    (takeImm && immSel == 8'hFE) |=> outData == $past(srcA0 | srcA1 | srcA2));

  // R5
  a_r5_blend: assert property (@(posedge clk) disable iff (rst)
    (takeImm && immSel == 8'hCA) |=>
      outData == $past((srcA0 & srcA1) | (~srcA0 & srcA2)));
endmodule

bind tern_logic_unit tlu_checker #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
  .opMode(opMode), .immSel(immSel), .srcA0(srcA0), .srcA1(srcA1),
  .srcA2(srcA2), .outValid(outValid), .outReady(outReady), .outData(outData)
);

// File: tb/tern_logic_unit_tb_top.sv
module tern_logic_unit_tb_top;
  localparam int DATA_W = 64;
  localparam int GROUP_W = 8;
  localparam int NG = DATA_W / GROUP_W;
  localparam int TBL_W = 8 * NG;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic inReady;
  logic opMode = 1'b0;
  logic [7:0] immSel = 8'h00;
  logic [TBL_W-1:0] tblSel = '0;
  logic [DATA_W-1:0] srcA0 = '0, srcA1 = '0, srcA2 = '0;
  logic outValid;
  logic outReady = 1'b1;
  logic [DATA_W-1:0] outData;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  tern_logic_unit #(.DATA_W(DATA_W), .GROUP_W(GROUP_W)) dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .opMode(opMode), .immSel(immSel), .tblSel(tblSel), .srcA0(srcA0),
    .srcA1(srcA1), .srcA2(srcA2), .outValid(outValid),
    .outReady(outReady), .outData(outData)
  );

  // Reference: index rule, A0 is index bit 2.
  function automatic logic [DATA_W-1:0] refEval(input logic mode, input logic [7:0] imm,
      input logic [TBL_W-1:0] tbl, input logic [DATA_W-1:0] a0,
      input logic [DATA_W-1:0] a1, input logic [DATA_W-1:0] a2);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) begin
      logic [7:0] t;
      int k;
      t = mode ? tbl[(i / GROUP_W) * 8 +: 8] : imm;
      k = (a0[i] ? 4 : 0) + (a1[i] ? 2 : 0) + (a2[i] ? 1 : 0);
      r[i] = t[k];
    end
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One transfer with a ready consumer; result checked one cycle later.
  task automatic xfer(input logic mode, input logic [7:0] imm, input logic [TBL_W-1:0] tbl,
      input logic [DATA_W-1:0] a0, input logic [DATA_W-1:0] a1,
      input logic [DATA_W-1:0] a2, input logic [DATA_W-1:0] exp, input string tag);
    @(negedge clk);
    opMode = mode; immSel = imm; tblSel = tbl;
    srcA0 = a0; srcA1 = a1; srcA2 = a2;
    inValid = 1'b1; outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk(outValid === 1'b1 && outData === exp, tag, outData, exp);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(outValid === 1'b0, "R10 reset outValid", {63'd0, outValid}, '0);
    chk(inReady === 1'b1, "R9 empty inReady", {63'd0, inReady}, 64'd1);
  endtask

  task automatic testIndexOrder();
    // Single-hot table: entry 4 is reached only with A0=1, A1=0, A2=0.
    xfer(1'b0, 8'h10, '0, 64'hFFFF_0000_FFFF_0000, 64'h00FF_00FF_00FF_00FF,
         64'h0F0F_0F0F_0F0F_0F0F,
         64'hFFFF_0000_FFFF_0000 & ~64'h00FF_00FF_00FF_00FF & ~64'h0F0F_0F0F_0F0F_0F0F,
         "R1 index order A0 msb");
    // Entry 1 only: A2 alone.
    xfer(1'b0, 8'h02, '0, 64'h0, 64'h0, 64'h1234_5678_9ABC_DEF0,
         64'h1234_5678_9ABC_DEF0, "R1 index order A2 lsb");
  endtask

  task automatic testSweep();
    for (int s = 0; s < 256; s++) begin
      logic [DATA_W-1:0] a0, a1, a2;
      xfer(1'b0, s[7:0], '0, '0, '0, '0, refEval(1'b0, s[7:0], '0, '0, '0, '0),
           "R2 sweep zeros");
      xfer(1'b0, s[7:0], '0, '1, '1, '1, refEval(1'b0, s[7:0], '0, '1, '1, '1),
           "R2 sweep ones");
      a0 = rnd64(); a1 = rnd64(); a2 = rnd64();
      xfer(1'b0, s[7:0], rnd64(), a0, a1, a2, refEval(1'b0, s[7:0], '0, a0, a1, a2),
           "R2 sweep random");
    end
  endtask

  task automatic testNamed();
    for (int n = 0; n < 4; n++) begin
      logic [DATA_W-1:0] a0, a1, a2;
      a0 = rnd64(); a1 = rnd64(); a2 = rnd64();
      xfer(1'b0, 8'h80, '0, a0, a1, a2, a0 & a1 & a2, "R3 triple AND");
      xfer(1'b0, 8'hFE, '0, a0, a1, a2, a0 | a1 | a2, "R4 triple OR");
      xfer(1'b0, 8'hCA, '0, a0, a1, a2, (a0 & a1) | (~a0 & a2), "R5 blend");
    end
  endtask

  task automatic testTableMode();
    logic [TBL_W-1:0] tbl;
    logic [DATA_W-1:0] exp;
    // Group g: table 0xF0 (copy A0) for even g, 0x0F (NOT A0) for odd g.
    for (int g = 0; g < NG; g++) tbl[g*8 +: 8] = (g % 2 == 0) ? 8'hF0 : 8'h0F;
    for (int g = 0; g < NG; g++)
      exp[g*GROUP_W +: GROUP_W] = (g % 2 == 0) ? 8'hA5 : 8'h5A;
    xfer(1'b1, 8'hFF, tbl, {NG{8'hA5}}, rnd64(), rnd64(), exp, "R6 group tables");
    for (int n = 0; n < 20; n++) begin
      logic [DATA_W-1:0] a0, a1, a2;
      logic [7:0] imm;
      a0 = rnd64(); a1 = rnd64(); a2 = rnd64(); tbl = rnd64(); imm = 8'($urandom());
      xfer(1'b1, imm, tbl, a0, a1, a2, refEval(1'b1, 8'h00, tbl, a0, a1, a2),
           "R6 random tables");
    end
  endtask

  task automatic testBackpressure();
    logic [DATA_W-1:0] exp1, exp2, a0, a1, a2;
    a0 = rnd64(); a1 = rnd64(); a2 = rnd64();
    exp1 = a0 & a1 & a2;
    @(negedge clk);
    opMode = 1'b0; immSel = 8'h80; srcA0 = a0; srcA1 = a1; srcA2 = a2;
    inValid = 1'b1; outReady = 1'b0;
    @(negedge clk);
    // Offer different inputs, including the other mode, while stalled.
    opMode = 1'b1; tblSel = '1; immSel = 8'h00;
    srcA0 = ~a0; exp2 = refEval(1'b1, 8'h00, '1, ~a0, a1, a2);
    chk(outValid === 1'b1 && outData === exp1, "R8 result after one cycle", outData, exp1);
    chk(inReady === 1'b0, "R9 inReady low when full", {63'd0, inReady}, '0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(outValid === 1'b1 && outData === exp1, "R7 held result ignores new inputs",
          outData, exp1);
    end
    outReady = 1'b1;
    #0;
    chk(inReady === 1'b1, "R9 inReady when draining", {63'd0, inReady}, 64'd1);
    @(negedge clk);
    inValid = 1'b0;
    chk(outValid === 1'b1 && outData === exp2, "R7 next capture uses current mode",
        outData, exp2);
    @(negedge clk);
    chk(outValid === 1'b0, "R8 drained empties output", {63'd0, outValid}, '0);
  endtask

  task automatic testMidReset();
    @(negedge clk);
    inValid = 1'b1; outReady = 1'b0; opMode = 1'b0; immSel = 8'hFF;
    @(negedge clk);
    inValid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(outValid === 1'b0, "R10 reset while full", {63'd0, outValid}, '0);
    outReady = 1'b1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testIndexOrder();
    testSweep();
    testNamed();
    testTableMode();
    testBackpressure();
    testMidReset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule